// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer with Process Tags

This block caches page-table entries so that a 32-bit virtual address can be turned into a physical address without a walk through memory. A single instance serves both instruction fetches and data accesses. Pages are 4 KB. A lookup presents the virtual address and the current process identifier. One clock later the block returns a hit flag, the 20-bit physical frame number, the 4-bit page attribute field (which holds data cacheability) and the assembled physical address.

Storage is organised as a number of ways. Each way holds one entry per set, and the set is chosen by the low bits of the virtual page number. Each entry stores a tag (page number, process identifier, global flag, valid bit) and a data part (frame number and attributes). Software loads entries through a write port and names the way itself, so the hardware has no replacement policy. An entry with the global flag set matches any process. Software must ensure that no two entries map the same address; if they do, the combined result is not defined.

Top module: `tlb_pid_lookup`

## Requirements
- R1: While reset is high and in the cycle after it, `res_valid` and `res_hit` are 0. After reset every entry is invalid, so every lookup misses until an entry is written.
- R2: A lookup hits when the set given by VA[12+IDX_W-1:12] holds a valid entry whose page number equals VA[31:12] and whose process identifier equals `lk_pid`. The result then carries that entry's frame number and attributes, with `res_paddr` = {frame, VA[11:0]}.
- R3: An entry whose global flag is 0 does not hit when its stored process identifier differs from `lk_pid`.
- R4: An entry whose global flag is 1 hits whatever the value of `lk_pid`.
- R5: An entry in the right set does not hit when its page number differs from VA[31:12] in any of the bits above the set index.
- R6: A write replaces only the entry at the way given by `wr_way` in the set given by the written page number. Other ways of that set keep their entries.
- R7: `res_valid` is 1 exactly one cycle after a cycle with `lk_valid` = 1. `res_hit` is never 1 while `res_valid` is 0. Lookups may be issued in consecutive cycles.
- R8: A lookup issued in the same cycle as a write sees the contents from before that write. Lookups in later cycles see the new entry.
- R9: A write with `wr_valid` = 0 invalidates the addressed entry, and it no longer hits.
- R10: Entries at the same way index but in different sets are independent.
- R11: On a miss with `res_valid` = 1, `res_pfn`, `res_attr` and `res_paddr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_pid | input | PID_W | Current process identifier |
| wr_en | input | 1 | Load an entry this cycle |
| wr_way | input | $clog2(NUM_WAYS) | Way chosen by software |
| wr_vpn | input | 20 | Page number of the entry; its low bits select the set |
| wr_pid | input | PID_W | Process identifier of the entry |
| wr_global | input | 1 | Entry matches every process |
| wr_valid | input | 1 | Valid bit written with the entry |
| wr_pfn | input | 20 | Physical frame number of the entry |
| wr_attr | input | 4 | Attributes {cacheable, user, writable, executable}, bit 3 first |
| res_valid | output | 1 | Result present (one cycle after a request) |
| res_hit | output | 1 | Translation found |
| res_pfn | output | 20 | Frame number, zero on a miss |
| res_attr | output | 4 | Page attributes, zero on a miss |
| res_paddr | output | 32 | Physical address, zero on a miss |

## Verification
The hardest case to reach from the ports is a set that holds several live entries that differ in only one field, because only then can a wrong way selection or a loose tag compare show up. The stimulus fills one set through chosen ways with entries that share the set index but differ in the upper page bits, then overwrites one of those ways, and checks each neighbour after every change. A write and a lookup to the same entry are also issued in the same cycle, followed by a second lookup, to check which contents the lookup sees.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W   = 32;
    localparam int OFFS_W = 12;
    localparam int VPN_W  = VA_W - OFFS_W;
    localparam int PFN_W  = 20;
    localparam int ATTR_W = 4;

    typedef struct packed {
        logic cacheable;
        logic user;
        logic writable;
        logic executable;
    } page_attr_t;

    typedef struct packed {
        logic             hit;
        logic [PFN_W-1:0] pfn;
        page_attr_t       attr;
    } xlate_t;

    function automatic logic [VA_W-1:0] join_paddr(input logic [PFN_W-1:0] pfn,
                                                   input logic [OFFS_W-1:0] offs);
        return {pfn, offs};
    endfunction

endpackage

// File: rtl/tlb_way.sv
module tlb_way
    import tlb_pkg::*;
#(
    parameter  int SETS  = 16,
    parameter  int PID_W = 8,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  logic             w_valid,
    input  logic [VPN_W-1:0] w_vpn,
    input  logic [PID_W-1:0] w_pid,
    input  logic             w_glob,
    input  logic [PFN_W-1:0] w_pfn,
    input  page_attr_t       w_attr,
    input  logic [IDX_W-1:0] r_idx,
    output logic             r_valid,
    output logic [VPN_W-1:0] r_vpn,
    output logic [PID_W-1:0] r_pid,
    output logic             r_glob,
    output logic [PFN_W-1:0] r_pfn,
    output page_attr_t       r_attr
);

    logic [SETS-1:0]  valid_q;
    logic [VPN_W-1:0] vpn_m  [SETS];
    logic [PID_W-1:0] pid_m  [SETS];
    logic             glob_m [SETS];
    logic [PFN_W-1:0] pfn_m  [SETS];
    page_attr_t       attr_m [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (we) begin
            valid_q[w_idx] <= w_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            vpn_m[w_idx]  <= w_vpn;
            pid_m[w_idx]  <= w_pid;
            glob_m[w_idx] <= w_glob;
            pfn_m[w_idx]  <= w_pfn;
            attr_m[w_idx] <= w_attr;
        end
    end

    always_comb begin
        r_valid = valid_q[r_idx];
        r_vpn   = vpn_m[r_idx];
        r_pid   = pid_m[r_idx];
        r_glob  = glob_m[r_idx];
        r_pfn   = pfn_m[r_idx];
        r_attr  = attr_m[r_idx];
    end

endmodule

// File: rtl/tlb_tag_cmp.sv
module tlb_tag_cmp
    import tlb_pkg::*;
#(
    parameter int PID_W = 8
) (
    input  logic             e_valid,
    input  logic [VPN_W-1:0] e_vpn,
    input  logic [PID_W-1:0] e_pid,
    input  logic             e_glob,
    input  logic [VPN_W-1:0] l_vpn,
    input  logic [PID_W-1:0] l_pid,
    output logic             match
);

    logic vpn_eq;
    logic pid_ok;

    always_comb begin
        vpn_eq = (e_vpn == l_vpn);
        pid_ok = e_glob || (e_pid == l_pid);
        match  = e_valid && vpn_eq && pid_ok;
    end

endmodule

// File: rtl/tlb_hit_merge.sv
module tlb_hit_merge
    import tlb_pkg::*;
#(
    parameter int WAYS = 16
) (
    input  logic [WAYS-1:0]             match,
    input  logic [WAYS-1:0][PFN_W-1:0]  pfn,
    input  page_attr_t [WAYS-1:0]       attr,
    output xlate_t                      result
);

    always_comb begin
        result = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) begin
                result.hit  = 1'b1;
                result.pfn  = result.pfn | pfn[w];
                result.attr = page_attr_t'(result.attr | attr[w]);
            end
        end
    end

endmodule

// File: rtl/tlb_pid_lookup.sv
module tlb_pid_lookup
    import tlb_pkg::*;
#(
    parameter  int NUM_ENTRIES = 256,
    parameter  int NUM_WAYS    = 16,
    parameter  int PID_W       = 8,
    localparam int SETS        = NUM_ENTRIES / NUM_WAYS,
    localparam int IDX_W       = $clog2(SETS),
    localparam int WAY_W       = $clog2(NUM_WAYS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lk_valid,
    input  logic [VA_W-1:0]     lk_vaddr,
    input  logic [PID_W-1:0]    lk_pid,
    input  logic                wr_en,
    input  logic [WAY_W-1:0]    wr_way,
    input  logic [VPN_W-1:0]    wr_vpn,
    input  logic [PID_W-1:0]    wr_pid,
    input  logic                wr_global,
    input  logic                wr_valid,
    input  logic [PFN_W-1:0]    wr_pfn,
    input  logic [ATTR_W-1:0]   wr_attr,
    output logic                res_valid,
    output logic                res_hit,
    output logic [PFN_W-1:0]    res_pfn,
    output logic [ATTR_W-1:0]   res_attr,
    output logic [VA_W-1:0]     res_paddr
);

    logic [VPN_W-1:0]  l_vpn;
    logic [OFFS_W-1:0] l_offs;
    logic [IDX_W-1:0]  l_idx;
    logic [IDX_W-1:0]  w_idx;

    assign l_vpn  = lk_vaddr[VA_W-1:OFFS_W];
    assign l_offs = lk_vaddr[OFFS_W-1:0];
    assign l_idx  = l_vpn[IDX_W-1:0];
    assign w_idx  = wr_vpn[IDX_W-1:0];

    logic [NUM_WAYS-1:0]             way_match;
    logic [NUM_WAYS-1:0][PFN_W-1:0]  way_pfn;
    page_attr_t [NUM_WAYS-1:0]       way_attr;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic             e_valid;
        logic [VPN_W-1:0] e_vpn;
        logic [PID_W-1:0] e_pid;
        logic             e_glob;
        logic             sel;

        assign sel = wr_en && (wr_way == WAY_W'(w));

        tlb_way #(
            .SETS  (SETS),
            .PID_W (PID_W)
        ) u_store (
            .clk     (clk),
            .rst     (rst),
            .we      (sel),
            .w_idx   (w_idx),
            .w_valid (wr_valid),
            .w_vpn   (wr_vpn),
            .w_pid   (wr_pid),
            .w_glob  (wr_global),
            .w_pfn   (wr_pfn),
            .w_attr  (page_attr_t'(wr_attr)),
            .r_idx   (l_idx),
            .r_valid (e_valid),
            .r_vpn   (e_vpn),
            .r_pid   (e_pid),
            .r_glob  (e_glob),
            .r_pfn   (way_pfn[w]),
            .r_attr  (way_attr[w])
        );

        tlb_tag_cmp #(
            .PID_W (PID_W)
        ) u_cmp (
            .e_valid (e_valid),
            .e_vpn   (e_vpn),
            .e_pid   (e_pid),
            .e_glob  (e_glob),
            .l_vpn   (l_vpn),
            .l_pid   (lk_pid),
            .match   (way_match[w])
        );
    end

    xlate_t merged;

    tlb_hit_merge #(
        .WAYS (NUM_WAYS)
    ) u_merge (
        .match  (way_match),
        .pfn    (way_pfn),
        .attr   (way_attr),
        .result (merged)
    );

    logic take;
    assign take = lk_valid && merged.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_pfn   <= '0;
            res_attr  <= '0;
            res_paddr <= '0;
        end else begin
            res_valid <= lk_valid;
            res_hit   <= take;
            res_pfn   <= take ? merged.pfn : '0;
            res_attr  <= take ? ATTR_W'(merged.attr) : '0;
            res_paddr <= take ? join_paddr(merged.pfn, l_offs) : '0;
        end
    end

endmodule

// File: rtl/tlb_pid_lookup_chk.sv
module tlb_pid_lookup_chk
    import tlb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic [VA_W-1:0]   lk_vaddr,
    input logic              res_valid,
    input logic              res_hit,
    input logic [PFN_W-1:0]  res_pfn,
    input logic [ATTR_W-1:0] res_attr,
    input logic [VA_W-1:0]   res_paddr
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!res_valid && !res_hit));

    p_req_to_result_r7: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid);

    p_no_spurious_result_r7: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !res_valid);

    p_hit_inside_result_r7: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> res_valid);

    p_paddr_assembly_r2: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> (res_paddr[OFFS_W-1:0] == $past(lk_vaddr[OFFS_W-1:0]))
                 && (res_paddr[VA_W-1:OFFS_W] == res_pfn));

    p_miss_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_pfn == '0 && res_attr == '0 && res_paddr == '0));

endmodule

bind tlb_pid_lookup tlb_pid_lookup_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .lk_vaddr  (lk_vaddr),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_pfn   (res_pfn),
    .res_attr  (res_attr),
    .res_paddr (res_paddr)
);

// File: tb/tlb_pid_lookup_tb.sv
module tlb_pid_lookup_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WAYS  = 16;
    localparam int PID_W = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_pid = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_way = '0;
    logic [19:0] wr_vpn = '0;
    logic [7:0]  wr_pid = '0;
    logic        wr_global = 1'b0;
    logic        wr_valid = 1'b0;
    logic [19:0] wr_pfn = '0;
    logic [3:0]  wr_attr = '0;
    logic        res_valid;
    logic        res_hit;
    logic [19:0] res_pfn;
    logic [3:0]  res_attr;
    logic [31:0] res_paddr;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_pid_lookup #(
        .NUM_ENTRIES (256),
        .NUM_WAYS    (WAYS),
        .PID_W       (PID_W)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .lk_valid  (lk_valid),
        .lk_vaddr  (lk_vaddr),
        .lk_pid    (lk_pid),
        .wr_en     (wr_en),
        .wr_way    (wr_way),
        .wr_vpn    (wr_vpn),
        .wr_pid    (wr_pid),
        .wr_global (wr_global),
        .wr_valid  (wr_valid),
        .wr_pfn    (wr_pfn),
        .wr_attr   (wr_attr),
        .res_valid (res_valid),
        .res_hit   (res_hit),
        .res_pfn   (res_pfn),
        .res_attr  (res_attr),
        .res_paddr (res_paddr)
    );

    typedef struct packed {
        logic        hit;
        logic [19:0] pfn;
        logic [3:0]  attr;
        logic [31:0] paddr;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    task automatic clear_inputs();
        lk_valid = 1'b0;
        wr_en    = 1'b0;
    endtask

    task automatic push_lookup(input logic [19:0] vpn, input logic [11:0] offs,
                               input logic [7:0] pid, input logic hit,
                               input logic [19:0] pfn, input logic [3:0] attr,
                               input string req);
        exp_t e;
        lk_valid = 1'b1;
        lk_vaddr = {vpn, offs};
        lk_pid   = pid;
        e.hit    = hit;
        e.pfn    = hit ? pfn : 20'h0;
        e.attr   = hit ? attr : 4'h0;
        e.paddr  = hit ? {pfn, offs} : 32'h0;
        exp_q.push_back(e);
        tag_q.push_back(req);
    endtask

    task automatic set_write(input logic [3:0] way, input logic [19:0] vpn,
                             input logic [7:0] pid, input logic glob, input logic vld,
                             input logic [19:0] pfn, input logic [3:0] attr);
        wr_en     = 1'b1;
        wr_way    = way;
        wr_vpn    = vpn;
        wr_pid    = pid;
        wr_global = glob;
        wr_valid  = vld;
        wr_pfn    = pfn;
        wr_attr   = attr;
    endtask

    task automatic do_lookup(input logic [19:0] vpn, input logic [11:0] offs,
                             input logic [7:0] pid, input logic hit,
                             input logic [19:0] pfn, input logic [3:0] attr,
                             input string req);
        @(negedge clk);
        clear_inputs();
        push_lookup(vpn, offs, pid, hit, pfn, attr, req);
    endtask

    task automatic do_write(input logic [3:0] way, input logic [19:0] vpn,
                            input logic [7:0] pid, input logic glob, input logic vld,
                            input logic [19:0] pfn, input logic [3:0] attr);
        @(negedge clk);
        clear_inputs();
        set_write(way, vpn, pid, glob, vld, pfn, attr);
    endtask

    // Monitor: results are compared against the scoreboard away from the clock edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (res_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R7: result with no request, hit=%0b", res_hit);
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (res_hit !== e.hit || res_pfn !== e.pfn ||
                        res_attr !== e.attr || res_paddr !== e.paddr) begin
                        fails++;
                        $display("FAIL %s: actual hit=%0b pfn=%h attr=%h paddr=%h expected hit=%0b pfn=%h attr=%h paddr=%h",
                                 t, res_hit, res_pfn, res_attr, res_paddr,
                                 e.hit, e.pfn, e.attr, e.paddr);
                    end
                end
            end else begin
                checks++;
                if (res_hit !== 1'b0) begin
                    fails++;
                    $display("FAIL R7: actual res_hit=%0b with no result, expected 0", res_hit);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R7: watchdog expired, actual pending=%0d expected 0", exp_q.size());
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_hit !== 1'b0) begin
            fails++;
            $display("FAIL R1: in reset actual valid=%0b hit=%0b expected 0 0", res_valid, res_hit);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_hit !== 1'b0) begin
            fails++;
            $display("FAIL R1: after reset actual valid=%0b hit=%0b expected 0 0", res_valid, res_hit);
        end

        // R1: empty storage misses everywhere
        do_lookup(20'h12345, 12'h678, 8'h05, 1'b0, 0, 0, "R1");
        do_lookup(20'h00000, 12'h000, 8'h00, 1'b0, 0, 0, "R1");
        do_lookup(20'hFFFFF, 12'hFFF, 8'hFF, 1'b0, 0, 0, "R1");

        // R2: plain hit with exact pid
        do_write(4'd3, 20'h12345, 8'h05, 1'b0, 1'b1, 20'hABCDE, 4'b1011);
        do_lookup(20'h12345, 12'h678, 8'h05, 1'b1, 20'hABCDE, 4'b1011, "R2");
        do_lookup(20'h12345, 12'h001, 8'h05, 1'b1, 20'hABCDE, 4'b1011, "R2");

        // R3: wrong pid, global clear
        do_lookup(20'h12345, 12'h678, 8'h06, 1'b0, 0, 0, "R3");

        // R4: global entry in set 1 hits any pid
        do_write(4'd7, 20'h00A31, 8'h09, 1'b1, 1'b1, 20'h55555, 4'b0001);
        do_lookup(20'h00A31, 12'h234, 8'h42, 1'b1, 20'h55555, 4'b0001, "R4");
        do_lookup(20'h00A31, 12'hABC, 8'h09, 1'b1, 20'h55555, 4'b0001, "R4");

        // R5: same set, different upper page bits
        do_lookup(20'h22345, 12'h678, 8'h05, 1'b0, 0, 0, "R5");
        do_lookup(20'h12355, 12'h678, 8'h05, 1'b0, 0, 0, "R5");

        // R6: a second way in the same set, then overwrite way 3
        do_write(4'd4, 20'h22345, 8'h05, 1'b0, 1'b1, 20'h11111, 4'b0010);
        do_lookup(20'h22345, 12'h010, 8'h05, 1'b1, 20'h11111, 4'b0010, "R6");
        do_lookup(20'h12345, 12'h010, 8'h05, 1'b1, 20'hABCDE, 4'b1011, "R6");
        do_write(4'd3, 20'h32345, 8'h05, 1'b0, 1'b1, 20'h77777, 4'b1100);
        do_lookup(20'h12345, 12'h010, 8'h05, 1'b0, 0, 0, "R6");
        do_lookup(20'h32345, 12'h020, 8'h05, 1'b1, 20'h77777, 4'b1100, "R6");
        do_lookup(20'h22345, 12'h030, 8'h05, 1'b1, 20'h11111, 4'b0010, "R6");

        // R10: same way, other set
        do_write(4'd3, 20'h12346, 8'h05, 1'b0, 1'b1, 20'h99999, 4'b0110);
        do_lookup(20'h32345, 12'h040, 8'h05, 1'b1, 20'h77777, 4'b1100, "R10");
        do_lookup(20'h12346, 12'h050, 8'h05, 1'b1, 20'h99999, 4'b0110, "R10");

        // R8: write and lookup of the same entry in one cycle
        @(negedge clk);
        clear_inputs();
        set_write(4'd0, 20'h40000, 8'h02, 1'b0, 1'b1, 20'h0F0F0, 4'b1001);
        push_lookup(20'h40000, 12'h123, 8'h02, 1'b0, 0, 0, "R8");
        do_lookup(20'h40000, 12'h123, 8'h02, 1'b1, 20'h0F0F0, 4'b1001, "R8");

        // R9: invalidate
        do_write(4'd0, 20'h40000, 8'h02, 1'b0, 1'b0, 20'h0F0F0, 4'b1001);
        do_lookup(20'h40000, 12'h123, 8'h02, 1'b0, 0, 0, "R9");

        // R2 / R3 at the top way and widest values
        do_write(4'd15, 20'hFFFFF, 8'hFF, 1'b0, 1'b1, 20'hFFFFF, 4'b1111);
        do_lookup(20'hFFFFF, 12'hFFF, 8'hFF, 1'b1, 20'hFFFFF, 4'b1111, "R2");
        do_lookup(20'hFFFFF, 12'hFFF, 8'hFE, 1'b0, 0, 0, "R3");

        // R7: burst of back-to-back lookups mixing hits and misses
        for (int i = 0; i < 6; i++) begin
            if (i % 2 == 0)
                do_lookup(20'h22345, 12'(i), 8'h05, 1'b1, 20'h11111, 4'b0010, "R7");
            else
                do_lookup(20'h52345, 12'(i), 8'h05, 1'b0, 0, 0, "R7");
        end

        @(negedge clk);
        clear_inputs();
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R7: actual pending=%0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule